// File: doc/BRIEF.md
# Programmable Frequency Output Divider

This block produces a square or pulse wave on a tri-statable output pin. It picks one of four source square waves and divides the chosen wave by a programmed ratio. Each divide code sets its own high-time fraction. The source waves arrive as levels that are synchronous to the system clock. Each rising edge of the selected source counts as one source period.

A force input, active low, overrides every register setting and sends the fastest source (32.768 kHz) straight to the pin. A chip-enable-high input gates the pin driver: when that input is low the pin floats, whatever the other inputs say. The divide code, source select and output enable sit in two nibble registers behind a small write/read port.

Top module: `freq_out_div`

## Requirements
- R1: Register 1 bits [1:0] pick the source: 00 is `src_lvl[0]` (32768 Hz), 01 is `src_lvl[1]` (1024 Hz), 10 is `src_lvl[2]` (32 Hz) and 11 is `src_lvl[3]` (1 Hz).
- R2: Register 0 bits [2:0] hold the divide code. Codes 0 to 7 divide the selected source by 1, 2, 3, 6, 5, 10, 15 and 30.
- R3: The output is high for this fraction of each divided period, listed by code 0 to 7: 1/2, 1/2, 1/3, 1/2, 1/5, 1/2, 1/3, 1/2.
- R4: Code 0 passes the selected source level straight through, so the source's own 50% duty is kept.
- R5: While `fix32k_n` is low and `ce_hi` is high, the pin is driven with `src_lvl[0]`. The enable bit, divide code and source select have no effect in this state.
- R6: While `fix32k_n` is high, the pin is driven with the divided signal when register 1 bit 2 is 1. When that bit is 0 the pin floats, which shows as `fout_oe`=0 and `fout`=0.
- R7: While `ce_hi` is low, `fout_oe` is 0 regardless of every other input.
- R8: A write that changes the divide code or the source select resets the period counter to 0 at that clock edge, so the output starts a fresh high phase. A write of the same value leaves the counter alone.
- R9: Reset clears all register bits. `reg_rdata` returns {0, code} for register 0 and {0, enable, select} for register 1.
- R10: The period counter always stays below the current ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register index (0: divide code, 1: select/enable) |
| reg_wdata | input | 4 | Write data nibble |
| reg_rdata | output | 4 | Read data nibble for `reg_addr` |
| src_lvl | input | 4 | Source square-wave levels, fastest first |
| fix32k_n | input | 1 | Low forces `src_lvl[0]` onto the pin |
| ce_hi | input | 1 | High permits the pin to be driven |
| fout | output | 1 | Output level (0 when not driven) |
| fout_oe | output | 1 | Output driver enable |

## Verification
A counter that wraps at the wrong value or compares against the wrong high length changes the period or the high width of `fout`. The error shows within one divided period of the output, which is at most 30 source periods. A wrong edge detector, or a select decode that points at the wrong source, scales both of these measures by the ratio between sources. A missing restart leaves `fout` low for the cycle right after a changing write, when it should be high. The enable and force logic shows up on `fout_oe` in the very next sample.

// File: rtl/freq_out_div.sv
module freq_out_div #(
  parameter int MAX_RATIO = 30,
  parameter int NSRC      = 4,
  localparam int CNT_W    = $clog2(MAX_RATIO),
  localparam int SEL_W    = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic            reg_addr,
  input  logic [3:0]      reg_wdata,
  output logic [3:0]      reg_rdata,
  input  logic [NSRC-1:0] src_lvl,
  input  logic            fix32k_n,
  input  logic            ce_hi,
  output logic            fout,
  output logic            fout_oe
);

  logic [2:0]       div_code;
  logic [SEL_W-1:0] src_sel;
  logic             out_en;
  logic [NSRC-1:0]  lvl_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] hi_len;

  always_comb begin
    case (div_code)
      3'd0:    begin ratio = CNT_W'(1);  hi_len = CNT_W'(0);  end
      3'd1:    begin ratio = CNT_W'(2);  hi_len = CNT_W'(1);  end
      3'd2:    begin ratio = CNT_W'(3);  hi_len = CNT_W'(1);  end
      3'd3:    begin ratio = CNT_W'(6);  hi_len = CNT_W'(3);  end
      3'd4:    begin ratio = CNT_W'(5);  hi_len = CNT_W'(1);  end
      3'd5:    begin ratio = CNT_W'(10); hi_len = CNT_W'(5);  end
      3'd6:    begin ratio = CNT_W'(15); hi_len = CNT_W'(5);  end
      default: begin ratio = CNT_W'(30); hi_len = CNT_W'(15); end
    endcase
  end

  wire sel_lvl = src_lvl[src_sel];
  wire tick    = sel_lvl & ~lvl_q[src_sel];
  wire wr0     = reg_we & ~reg_addr;
  wire wr1     = reg_we &  reg_addr;
  wire cfg_chg = (wr0 && reg_wdata[2:0] != div_code) ||
                 (wr1 && reg_wdata[SEL_W-1:0] != src_sel);
  wire at_wrap = (cnt == ratio - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_code <= '0;
      src_sel  <= '0;
      out_en   <= 1'b0;
    end else begin
      if (wr0) div_code <= reg_wdata[2:0];
      if (wr1) begin
        src_sel <= reg_wdata[SEL_W-1:0];
        out_en  <= reg_wdata[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      cnt   <= '0;
    end else begin
      lvl_q <= src_lvl;
      if (cfg_chg)   cnt <= '0;
      else if (tick) cnt <= at_wrap ? '0 : cnt + CNT_W'(1);
    end
  end

  wire div_lvl = (div_code == 3'd0) ? sel_lvl : (cnt < hi_len);

  assign fout_oe   = ce_hi & (~fix32k_n | out_en);
  assign fout      = fout_oe & (fix32k_n ? div_lvl : src_lvl[0]);
  assign reg_rdata = reg_addr ? {1'b0, out_en, 2'(src_sel)} : {1'b0, div_code};

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> cnt == '0);

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_chg && !at_wrap) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reg_we) |=> $stable(cnt));

  // R6
  float_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fout_oe |-> !fout);

  // R7
  ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_hi |-> !fout_oe);

endmodule

// File: tb/freq_out_div_bench.sv
module freq_out_div_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_addr = 1'b0;
  logic [3:0] reg_wdata = 4'd0;
  logic [3:0] reg_rdata;
  logic       fix32k_n = 1'b1;
  logic       ce_hi = 1'b0;
  logic       fout, fout_oe;
  logic [7:0] bcnt = 8'd0;
  logic [3:0] src_lvl;

  int n_chk = 0, n_fail = 0;
  int m_per, m_hi;
  bit timeout = 0;

  always #2.5 clk = ~clk;
  assign src_lvl = bcnt[4:1];

  initial forever begin
    @(negedge clk);
    bcnt <= bcnt + 8'd1;
  end

  freq_out_div u_freq_out_div (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_lvl(src_lvl),
    .fix32k_n(fix32k_n), .ce_hi(ce_hi), .fout(fout), .fout_oe(fout_oe));

  // {select[1:0], code[2:0], period[9:0], high[9:0]}; source i period = 4<<i cycles
  localparam logic [24:0] VEC [12] = '{
    {2'd0, 3'd0, 10'd4,   10'd2},
    {2'd0, 3'd1, 10'd8,   10'd4},
    {2'd0, 3'd2, 10'd12,  10'd4},
    {2'd0, 3'd3, 10'd24,  10'd12},
    {2'd0, 3'd4, 10'd20,  10'd4},
    {2'd1, 3'd5, 10'd80,  10'd40},
    {2'd1, 3'd6, 10'd120, 10'd40},
    {2'd0, 3'd7, 10'd120, 10'd60},
    {2'd2, 3'd2, 10'd48,  10'd16},
    {2'd3, 3'd7, 10'd960, 10'd480},
    {2'd3, 3'd0, 10'd32,  10'd16},
    {2'd2, 3'd4, 10'd80,  10'd16}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [3:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
  endtask

  task automatic wait_lvl(logic v);
    for (int i = 0; i < 4000 && fout != v; i++) step();
    if (fout != v) timeout = 1;
  endtask

  task automatic measure();
    m_per = 0; m_hi = 0;
    wait_lvl(1'b0);
    wait_lvl(1'b1);
    for (int i = 0; i < 4000 && fout; i++) begin step(); m_hi++; end
    m_per = m_hi;
    for (int i = 0; i < 4000 && !fout; i++) begin step(); m_per++; end
  endtask

  initial begin
    #750000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R9, R7: reset state
    chk("R9 reset reg0", reg_rdata, 0);
    reg_addr = 1'b1; #1;
    chk("R9 reset reg1", reg_rdata, 0);
    chk("R7 ce_hi low floats", fout_oe, 0);
    rst_n = 1'b1;
    step();
    ce_hi = 1'b1; #1;
    chk("R6 enable clear floats", fout_oe, 0);

    // R1 R2 R3 R4: table walk
    foreach (VEC[k]) begin
      logic [1:0] s;
      logic [2:0] c;
      s = VEC[k][24:23];
      c = VEC[k][22:20];
      wr(1'b0, {1'b0, c});
      wr(1'b1, {1'b0, 1'b1, s});
      chk("R9 readback select/enable", reg_rdata, {1'b0, 1'b1, s});
      measure();
      measure();
      chk($sformatf("R1 R2 period sel=%0d code=%0d", s, c), m_per, int'(VEC[k][19:10]));
      chk($sformatf("R3 R4 high sel=%0d code=%0d", s, c), m_hi, int'(VEC[k][9:0]));
    end

    // R8: restart on change, no restart on same value
    wr(1'b1, 4'b0111);
    wr(1'b0, 4'd7);
    measure();
    wait_lvl(1'b0);
    repeat (20) step();
    wr(1'b0, 4'd7);
    chk("R8 same-value write keeps low phase", fout, 0);
    wr(1'b0, 4'd6);
    chk("R8 changing write restarts high", fout, 1);
    wait_lvl(1'b0);
    repeat (20) step();
    wr(1'b1, 4'b0110);
    chk("R8 select change restarts high", fout, 1);

    // R6: enable cleared
    wr(1'b1, 4'b0010);
    chk("R6 enable 0 oe", fout_oe, 0);
    chk("R6 enable 0 level", fout, 0);

    // R5: force low overrides enable and code
    wr(1'b0, 4'd5);
    fix32k_n = 1'b0;
    step();
    chk("R5 force drives", fout_oe, 1);
    measure();
    chk("R5 force period", m_per, 4);
    chk("R5 force high", m_hi, 2);

    // R7: ce_hi low wins over force
    ce_hi = 1'b0; #1;
    chk("R7 ce_hi low with force", fout_oe, 0);
    chk("R7 ce_hi low level", fout, 0);

    if (timeout) begin
      n_chk++; n_fail++;
      $display("FAIL R3 edge wait actual=timeout expected=edge");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule